// File: doc/BRIEF.md
# Protection Region Matcher with Memory-Attribute Decode

The block checks each bus access against a small table of protection regions. Every region has a base address, a size that is a power of two, an eight-bit mask that switches off subregions, and an attribute word. An access arrives with its address and with write, instruction-fetch and privilege flags. One cycle later the block returns the index of the winning region, the decoded memory type, the shareability and the caching policy, a flag for reserved attribute encodings, and a permission-fault flag. Software writes the region table through a single-cycle write port.

Accesses enter on a valid/ready channel, and results leave on a second valid/ready channel. The block holds one result register. It accepts a new access whenever that register is empty or is being drained in the same cycle. A result that waits with `res_ready` low stays frozen, and `acc_ready` stays low while it waits. The first faulting access is recorded as an address and a code. The record holds until `flt_clr` is pulsed.

Top module: `mpu_check`

## Requirements
- R1: Region n matches when it is enabled and address bits [AW-1:size] equal the same bits of its base. `cfg_size` is log2 of the size in bytes and is at least 5.
- R2: A region is split into eight equal subregions. Bit k of `cfg_srd` set removes subregion k from the match, with k=0 being the lowest addresses. An address in a removed subregion can then match another overlapping region.
- R3: When several regions match, the one with the largest index wins and is reported on `res_region`.
- R4: The attribute word is {xn[10], ap_priv[9:8], ap_user[7:6], tex[5:3], s[2], c[1], b[0]}. Memory type is coded 0 strongly ordered, 1 device, 2 normal. Caching policy is coded 0 none, 1 write-through, 2 write-back, 3 write-back with allocate. With tex=000: c=0,b=0 gives type 0, shared. c=0,b=1 gives type 1, shared. In both of these cases s is ignored. c=1 gives normal memory, with policy 1 when b=0 and policy 2 when b=1, and with shareability equal to s.
- R5: tex=001 with c=b=0 gives normal memory with policy 0. tex=001 with c=b=1 gives normal memory with policy 3. In both cases shareability equals s. tex=010 with c=b=0 gives device memory, not shared. Every other combination sets `res_rsvd` and reports type 0, not shared, policy 0.
- R6: The rights field is chosen by `acc_priv`. Its codes are 0 no access, 1 read-only, 2 or 3 read/write. An access that the selected field does not permit sets `res_fault`, with fault code 2.
- R7: An instruction fetch from a region whose xn bit is set faults with code 3, whatever the rights field says.
- R8: An access that matches no region reports `res_hit`=0, region 0 and zero attributes. It faults with code 1 unless it is privileged and `dflt_en` is 1.
- R9: A result appears the cycle after its access is accepted. While `res_valid` is high and `res_ready` is low, the result holds steady and `acc_ready` is low.
- R10: When a faulting access is accepted and no fault is recorded, `flt_addr` and `flt_code` capture it and `flt_valid` rises. Later faults do not change the record. `flt_clr` empties the record.
- R11: After reset all regions are disabled, `res_valid` and `flt_valid` are 0, and `acc_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write one region entry |
| cfg_idx | input | IW | Region being written |
| cfg_en | input | 1 | Region enable |
| cfg_base | input | AW | Region base address |
| cfg_size | input | SW | log2 of the region size in bytes |
| cfg_srd | input | 8 | Subregion disable mask |
| cfg_attr | input | 11 | Attribute word |
| dflt_en | input | 1 | Let privileged unmatched accesses through |
| acc_valid | input | 1 | Access valid |
| acc_ready | output | 1 | Access accepted this cycle |
| acc_addr | input | AW | Access address |
| acc_write | input | 1 | Write access |
| acc_fetch | input | 1 | Instruction fetch |
| acc_priv | input | 1 | Privileged access |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumer ready |
| res_hit | output | 1 | A region matched |
| res_region | output | IW | Winning region |
| res_mtype | output | 2 | Memory type |
| res_share | output | 1 | Shareable |
| res_cpol | output | 2 | Caching policy |
| res_rsvd | output | 1 | Reserved attribute encoding |
| res_fault | output | 1 | Permission fault |
| flt_clr | input | 1 | Clear fault record |
| flt_valid | output | 1 | Fault record held |
| flt_addr | output | AW | Address of first fault |
| flt_code | output | 2 | 1 no match, 2 rights, 3 execute-never |

## Verification
The bench builds two overlapping regions that share a base. The larger region has its two lowest subregions switched off, so an address in those subregions must fall through to the smaller region. A design that ignored the mask, or counted subregions from the wrong end, would report the larger region there instead. The bench then sweeps the encodings of the type fields, including both reserved families and the s bit that must be ignored. It also exercises the rules for unmatched addresses, the priority of execute-never over rights, a result that is held under back-pressure, and a second fault that must not overwrite the first. A decoder with a swapped row, a priority that favours low indices, or a fault record that is not sticky would each produce a wrong result word or a wrong record.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  typedef enum logic [1:0] {MT_STRONG = 2'd0, MT_DEVICE = 2'd1, MT_NORMAL = 2'd2} mtype_e;
  typedef enum logic [1:0] {CP_NONE = 2'd0, CP_WT = 2'd1, CP_WB = 2'd2, CP_WBA = 2'd3} cpol_e;

  typedef struct packed {
    logic       xn;
    logic [1:0] ap_priv;
    logic [1:0] ap_user;
    logic [2:0] tex;
    logic       s;
    logic       c;
    logic       b;
  } attr_t;

  typedef struct packed {
    mtype_e mtype;
    logic   share;
    cpol_e  cpol;
    logic   rsvd;
  } mem_t;

  localparam logic [1:0] FC_NOMATCH = 2'd1;
  localparam logic [1:0] FC_PERM    = 2'd2;
  localparam logic [1:0] FC_XN      = 2'd3;
  localparam logic [1:0] RT_NONE    = 2'd0;
  localparam logic [1:0] RT_RO      = 2'd1;
endpackage

// File: rtl/mpu_region_match.sv
module mpu_region_match #(
  parameter int AW = 32,
  parameter int SW = 5
) (
  input  logic          en,
  input  logic [AW-1:0] base,
  input  logic [SW-1:0] size,
  input  logic [7:0]    srd,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  logic [AW-1:0] mask;
  logic [AW-1:0] sub_sh;
  logic [2:0]    sub;
  logic          in_range;

  always_comb begin
    mask     = {AW{1'b1}} << size;
    in_range = ((addr ^ base) & mask) == '0;
    sub_sh   = addr >> (size - SW'(3));
    sub      = sub_sh[2:0];
    hit      = en && in_range && !srd[sub];
  end
endmodule

// File: rtl/mpu_attr_decode.sv
module mpu_attr_decode
  import mpu_pkg::*;
(
  input  attr_t attr,
  output mem_t  mem
);
  always_comb begin
    mem = '{mtype: MT_STRONG, share: 1'b0, cpol: CP_NONE, rsvd: 1'b0};
    unique case (attr.tex)
      3'b000: begin
        if (!attr.c) begin
          mem.mtype = attr.b ? MT_DEVICE : MT_STRONG;
          mem.share = 1'b1;
        end else begin
          mem.mtype = MT_NORMAL;
          mem.share = attr.s;
          mem.cpol  = attr.b ? CP_WB : CP_WT;
        end
      end
      3'b001: begin
        if (attr.c != attr.b) mem.rsvd = 1'b1;
        else begin
          mem.mtype = MT_NORMAL;
          mem.share = attr.s;
          mem.cpol  = attr.c ? CP_WBA : CP_NONE;
        end
      end
      3'b010: begin
        if (attr.c || attr.b) mem.rsvd = 1'b1;
        else mem.mtype = MT_DEVICE;
      end
      default: mem.rsvd = 1'b1;
    endcase
  end
endmodule

// File: rtl/mpu_check.sv
module mpu_check
  import mpu_pkg::*;
#(
  parameter int NREG = 4,
  parameter int AW   = 32,
  parameter int SW   = 5,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic          cfg_en,
  input  logic [AW-1:0] cfg_base,
  input  logic [SW-1:0] cfg_size,
  input  logic [7:0]    cfg_srd,
  input  logic [10:0]   cfg_attr,
  input  logic          dflt_en,
  input  logic          acc_valid,
  output logic          acc_ready,
  input  logic [AW-1:0] acc_addr,
  input  logic          acc_write,
  input  logic          acc_fetch,
  input  logic          acc_priv,
  output logic          res_valid,
  input  logic          res_ready,
  output logic          res_hit,
  output logic [IW-1:0] res_region,
  output logic [1:0]    res_mtype,
  output logic          res_share,
  output logic [1:0]    res_cpol,
  output logic          res_rsvd,
  output logic          res_fault,
  input  logic          flt_clr,
  output logic          flt_valid,
  output logic [AW-1:0] flt_addr,
  output logic [1:0]    flt_code
);
  logic          en_q   [NREG];
  logic [AW-1:0] base_q [NREG];
  logic [SW-1:0] size_q [NREG];
  logic [7:0]    srd_q  [NREG];
  attr_t         attr_q [NREG];
  logic [NREG-1:0] hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        en_q[i]   <= 1'b0;
        base_q[i] <= '0;
        size_q[i] <= SW'(5);
        srd_q[i]  <= '0;
        attr_q[i] <= '0;
      end
    end else if (cfg_we) begin
      en_q[cfg_idx]   <= cfg_en;
      base_q[cfg_idx] <= cfg_base;
      size_q[cfg_idx] <= cfg_size;
      srd_q[cfg_idx]  <= cfg_srd;
      attr_q[cfg_idx] <= attr_t'(cfg_attr);
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_rgn
    mpu_region_match #(.AW(AW), .SW(SW)) u_match (
      .en(en_q[g]), .base(base_q[g]), .size(size_q[g]),
      .srd(srd_q[g]), .addr(acc_addr), .hit(hit[g])
    );
  end

  logic          win_hit;
  logic [IW-1:0] win_idx;
  attr_t         win_attr;
  mem_t          win_mem;
  logic [1:0]    rights;
  logic          n_fault;
  logic [1:0]    n_code;

  always_comb begin
    win_hit = 1'b0;
    win_idx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) begin
        win_hit = 1'b1;
        win_idx = IW'(i);
      end
    end
    win_attr = attr_q[win_idx];
  end

  mpu_attr_decode u_dec (.attr(win_attr), .mem(win_mem));

  always_comb begin
    rights  = acc_priv ? win_attr.ap_priv : win_attr.ap_user;
    n_fault = 1'b0;
    n_code  = FC_NOMATCH;
    if (!win_hit) begin
      n_fault = !(acc_priv && dflt_en);
    end else if (acc_fetch && win_attr.xn) begin
      n_fault = 1'b1;
      n_code  = FC_XN;
    end else if (rights == RT_NONE || (rights == RT_RO && acc_write)) begin
      n_fault = 1'b1;
      n_code  = FC_PERM;
    end
  end

  logic xfer;
  assign acc_ready = !res_valid || res_ready;
  assign xfer      = acc_valid && acc_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_region <= '0;
      res_mtype  <= '0;
      res_share  <= 1'b0;
      res_cpol   <= '0;
      res_rsvd   <= 1'b0;
      res_fault  <= 1'b0;
    end else if (xfer) begin
      res_valid  <= 1'b1;
      res_hit    <= win_hit;
      res_region <= win_hit ? win_idx : '0;
      res_mtype  <= win_hit ? win_mem.mtype : MT_STRONG;
      res_share  <= win_hit && win_mem.share;
      res_cpol   <= win_hit ? win_mem.cpol : CP_NONE;
      res_rsvd   <= win_hit && win_mem.rsvd;
      res_fault  <= n_fault;
    end else if (res_ready) begin
      res_valid  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_valid <= 1'b0;
      flt_addr  <= '0;
      flt_code  <= '0;
    end else if (xfer && n_fault && (!flt_valid || flt_clr)) begin
      flt_valid <= 1'b1;
      flt_addr  <= acc_addr;
      flt_code  <= n_code;
    end else if (flt_clr) begin
      flt_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mpu_check_sva.sv
module mpu_check_sva #(
  parameter int AW = 32,
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          acc_ready,
  input logic          res_valid,
  input logic          res_ready,
  input logic          res_hit,
  input logic [IW-1:0] res_region,
  input logic          res_rsvd,
  input logic          res_fault,
  input logic          flt_clr,
  input logic          flt_valid,
  input logic [AW-1:0] flt_addr
);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_region) && $stable(res_fault) && $stable(res_hit));

  a_r9_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> acc_ready);

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && !flt_clr |=> flt_valid && $stable(flt_addr));

  a_r10_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_valid) |-> $past(acc_valid && acc_ready));

  a_r8_nohit: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> !res_rsvd && res_region == '0);
endmodule

bind mpu_check mpu_check_sva #(.AW(AW), .IW(IW)) u_sva (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
  .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit),
  .res_region(res_region), .res_rsvd(res_rsvd), .res_fault(res_fault),
  .flt_clr(flt_clr), .flt_valid(flt_valid), .flt_addr(flt_addr)
);

// File: tb/sim_mpu_check.sv
module sim_mpu_check;
  localparam int AW = 32;
  localparam int SW = 5;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          cfg_we = 0, cfg_en = 0;
  logic [IW-1:0] cfg_idx = '0;
  logic [AW-1:0] cfg_base = '0;
  logic [SW-1:0] cfg_size = SW'(5);
  logic [7:0]    cfg_srd = '0;
  logic [10:0]   cfg_attr = '0;
  logic          dflt_en = 1'b1;
  logic          acc_valid = 0, acc_write = 0, acc_fetch = 0, acc_priv = 0;
  logic [AW-1:0] acc_addr = '0;
  logic          acc_ready, res_valid, res_hit, res_share, res_rsvd, res_fault;
  logic          res_ready = 1'b1, flt_clr = 1'b0, flt_valid;
  logic [IW-1:0] res_region;
  logic [1:0]    res_mtype, res_cpol, flt_code;
  logic [AW-1:0] flt_addr;

  mpu_check #(.NREG(4), .AW(AW), .SW(SW)) u0 (.*);

  int n_chk = 0, n_bad = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] E(logic h, logic [1:0] rg, logic [1:0] mt, logic sh,
                                   logic [1:0] cp, logic rs, logic f);
    return {h, rg, mt, sh, cp, rs, f};
  endfunction

  function automatic logic [10:0] A(logic xn, logic [1:0] app, logic [1:0] apu,
                                    logic [2:0] tex, logic s, logic c, logic b);
    return {xn, app, apu, tex, s, c, b};
  endfunction

  always @(negedge clk) begin
    #2;
    if (rst_n && res_valid && res_ready) begin
      if (exp_q.size() == 0) check("R9 unexpected result", 1, 0);
      else check(tag_q.pop_front(),
                 {res_hit, res_region, res_mtype, res_share, res_cpol, res_rsvd, res_fault},
                 exp_q.pop_front());
    end
  end

  task automatic prog(int idx, logic en, logic [AW-1:0] base, int sz, logic [7:0] srd,
                      logic [10:0] attr);
    @(negedge clk);
    cfg_we = 1; cfg_idx = IW'(idx); cfg_en = en; cfg_base = base;
    cfg_size = SW'(sz); cfg_srd = srd; cfg_attr = attr;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(logic [AW-1:0] a, logic wr, logic fe, logic pr, logic [9:0] e, string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    acc_valid = 1; acc_addr = a; acc_write = wr; acc_fetch = fe; acc_priv = pr;
    #1;
    while (!acc_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    acc_valid = 0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_fault();
    @(negedge clk); flt_clr = 1;
    @(negedge clk); flt_clr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R11 res_valid", res_valid, 0);
    check("R11 flt_valid", flt_valid, 0);
    check("R11 acc_ready", acc_ready, 1);
    send(32'h1000, 0, 0, 1, E(0,0,0,0,0,0,0), "R11 regions disabled");
    drain();

    prog(0, 1, 32'h0, 17, 8'h00, A(0,2'd2,2'd1,3'b000,1,1,0));
    prog(1, 1, 32'h0, 19, 8'h03, A(1,2'd2,2'd0,3'b001,0,1,1));
    prog(2, 1, 32'h100000, 12, 8'h00, A(0,2'd2,2'd2,3'b000,0,0,1));
    prog(3, 1, 32'h200000, 12, 8'h00, A(0,2'd1,2'd2,3'b010,0,1,0));

    send(32'h1000,   0,0,1, E(1,0,2,1,1,0,0), "R2 subregion0 falls through");
    send(32'h1000,   1,0,0, E(1,0,2,1,1,0,1), "R6 user write to read-only");
    send(32'h18000,  0,0,0, E(1,0,2,1,1,0,0), "R2 subregion1 falls through");
    send(32'h20000,  0,0,1, E(1,1,2,0,3,0,0), "R1 R5 large region hit");
    send(32'h20000,  0,0,0, E(1,1,2,0,3,0,1), "R6 user no access");
    send(32'h20000,  0,1,1, E(1,1,2,0,3,0,1), "R7 xn fetch");
    send(32'h100010, 1,0,0, E(1,2,1,1,0,0,0), "R4 device shared");
    send(32'h200000, 1,0,1, E(1,3,0,0,0,1,1), "R5 R6 reserved, priv read-only");
    send(32'h200000, 1,0,0, E(1,3,0,0,0,1,0), "R5 reserved, user read/write");
    send(32'h90000,  0,0,1, E(0,0,0,0,0,0,0), "R8 unmatched priv allowed");
    send(32'h90000,  0,0,0, E(0,0,0,0,0,0,1), "R8 unmatched user faults");
    drain();
    check("R10 first fault kept", flt_valid, 1);
    check("R10 first fault addr", flt_addr, 32'h1000);
    check("R10 first fault code", flt_code, 2);
    clear_fault();
    @(negedge clk);
    check("R10 clear", flt_valid, 0);

    dflt_en = 0;
    send(32'h90000, 0,0,1, E(0,0,0,0,0,0,1), "R8 unmatched priv without default");
    drain();
    check("R8 nomatch code", flt_code, 1);
    check("R8 nomatch addr", flt_addr, 32'h90000);
    clear_fault();
    dflt_en = 1;

    send(32'h20000, 0,1,1, E(1,1,2,0,3,0,1), "R7 xn fetch again");
    drain();
    check("R7 xn code", flt_code, 3);
    check("R7 xn addr", flt_addr, 32'h20000);
    clear_fault();

    prog(2, 1, 32'h100000, 12, 8'h00, A(0,2'd2,2'd2,3'b000,0,0,0));
    send(32'h100000, 0,0,1, E(1,2,0,1,0,0,0), "R4 strongly ordered");
    prog(2, 1, 32'h100000, 12, 8'h00, A(0,2'd2,2'd2,3'b000,1,0,0));
    send(32'h100000, 0,0,1, E(1,2,0,1,0,0,0), "R4 s ignored");
    prog(2, 1, 32'h100000, 12, 8'h00, A(0,2'd2,2'd2,3'b000,0,1,1));
    send(32'h100000, 0,0,1, E(1,2,2,0,2,0,0), "R4 write-back");
    prog(2, 1, 32'h100000, 12, 8'h00, A(0,2'd2,2'd2,3'b001,1,0,0));
    send(32'h100000, 0,0,1, E(1,2,2,1,0,0,0), "R5 non-cacheable");
    prog(2, 1, 32'h100000, 12, 8'h00, A(0,2'd2,2'd2,3'b010,1,0,0));
    send(32'h100000, 0,0,1, E(1,2,1,0,0,0,0), "R5 non-shared device");
    prog(2, 1, 32'h100000, 12, 8'h00, A(0,2'd2,2'd2,3'b001,0,1,0));
    send(32'h100000, 0,0,1, E(1,2,0,0,0,1,0), "R5 reserved c!=b");
    prog(2, 1, 32'h100000, 12, 8'h00, A(0,2'd2,2'd2,3'b010,0,0,1));
    send(32'h100000, 0,0,1, E(1,2,0,0,0,1,0), "R5 reserved b=1");

    prog(1, 1, 32'h0, 19, 8'h00, A(1,2'd2,2'd0,3'b001,0,1,1));
    send(32'h1000, 0,0,1, E(1,1,2,0,3,0,0), "R3 highest index wins");
    prog(1, 1, 32'h0, 19, 8'h80, A(1,2'd2,2'd0,3'b001,0,1,1));
    send(32'h7F000, 0,0,1, E(0,0,0,0,0,0,0), "R2 top subregion disabled");
    send(32'h6F000, 0,0,1, E(1,1,2,0,3,0,0), "R2 subregion6 still enabled");
    drain();
    clear_fault();

    res_ready = 0;
    send(32'h100010, 0,0,1, E(1,2,0,0,0,1,0), "R9 result after stall");
    for (int k = 0; k < 3; k++) begin
      check("R9 held valid", res_valid, 1);
      check("R9 ready low", acc_ready, 0);
      check("R9 held region", res_region, 2);
      @(negedge clk);
    end
    res_ready = 1;
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule